// File: doc/BRIEF.md
# Chunked FIFO Transfer Controller

This block runs one data transfer between a system bus and a card through a byte-granular staging FIFO. Software writes a single control word that holds the byte count, the direction, the card word width, some mode qualifiers and a start bit. While the transfer runs, the bus side pushes 32-bit words into the FIFO for a write, or pops them out for a read. The card side moves one 8-bit or 16-bit word per handshake beat.

Bytes crossing the card side are counted in FIFO-sized chunks. The block pulses a buffer-available event when a full chunk is ready for the bus to read, or when a chunk's worth of space has been freed for the bus to refill. It pulses a done event once the programmed count has crossed the card interface. The start bit reads back as the busy flag. Software can abort a transfer by writing the start bit low. A card-side PIO error input also stops the transfer.

Top module: `chunk_xfer_ctrl`

## Requirements
- R1: After reset, the control readback is zero, and card request, bus push-ready, bus pop-valid, buffer-available and done are all low.
- R2: A control write with bit 31 set while idle starts a transfer and flushes the FIFO. The field positions are: bit 30 direction (1 = toward card), bit 28 DMA mode, bit 27 I/O space, bit 26 attribute memory, bit 25 16-bit card width, bit 24 no address increment, count in bits COUNT_W-1:0. The readback shows those fields and bit 31 as busy.
- R3: In a read, card words enter the FIFO low byte first. The bus pops them as little-endian 32-bit words, four bytes per pop, or the remainder once the transfer is idle.
- R4: In a write, bus words are pushed four bytes at a time, and card_wdata_o presents the bytes in push order, low byte first.
- R5: In a read, buffer_avail pulses for one cycle after each beat that completes a FIFO-sized chunk, including the chunk that ends the transfer.
- R6: In a write, buffer_avail pulses after each completed chunk except the one that ends the transfer.
- R7: After the beat that moves the last byte, done pulses for exactly one cycle and the start bit reads back low. A final chunk shorter than the FIFO gives done only.
- R8: With 16-bit width, a beat moves two bytes, except when one byte remains; then the beat moves one byte and the total moved equals the count.
- R9: A start with count zero pulses done on the next cycle without ever requesting a card beat.
- R10: A count larger than MAX_XFER is clamped to MAX_XFER, and the readback shows the clamped value.
- R11: A control write with bit 31 set while busy is ignored: the readback bits 30..0 and the running transfer are unchanged.
- R12: A control write with bit 31 clear while busy aborts the transfer. Busy drops on the next cycle, no done or buffer event follows, and the card request stays low.
- R13: pio_err_i high while busy stops the transfer with no done event.
- R14: The card request is raised only while busy and only when the FIFO holds enough data (write) or space (read) for the next beat. Bus push-ready requires four free bytes, and the FIFO level never exceeds FIFO_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word |
| ctrl_rdata_o | output | 32 | Control readback, bit 31 = busy |
| bus_push_i | input | 1 | Bus pushes a word (write direction) |
| bus_wdata_i | input | 8*BUS_BYTES | Bus push data |
| bus_push_ready_o | output | 1 | FIFO can take a bus word |
| bus_pop_i | input | 1 | Bus pops a word (read direction) |
| bus_rdata_o | output | 8*BUS_BYTES | Bus pop data |
| bus_pop_valid_o | output | 1 | Bus pop data available |
| card_req_o | output | 1 | Card beat requested |
| card_ack_i | input | 1 | Card completes the beat this cycle |
| card_wide_o | output | 1 | Card beat is 16-bit |
| card_rdata_i | input | 16 | Data from card |
| card_wdata_o | output | 16 | Data to card |
| pio_err_i | input | 1 | Card transfer error |
| buf_avail_o | output | 1 | Chunk ready / space freed pulse |
| xfer_done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with a 16-byte FIFO and MAX_XFER of 40 instead of 512 bytes and 0x20000. With these values, multi-chunk transfers, short final chunks, FIFO-full and FIFO-empty stalls, and the count clamp all occur within a few dozen cycles. The card acknowledge is withheld on every third cycle and the bus pops only every fourth cycle during a read, so both flow-control limits are exercised. Abort, PIO error and the ignored restart are injected mid-transfer at a fixed cycle.

// File: rtl/cfx_pkg.sv
`timescale 1ns/1ps
package cfx_pkg;
  localparam int START_BIT = 31;
  localparam int DIR_BIT   = 30;
  localparam int DMA_BIT   = 28;
  localparam int IO_BIT    = 27;
  localparam int ATTR_BIT  = 26;
  localparam int WIDE_BIT  = 25;
  localparam int NOINC_BIT = 24;

  typedef struct packed {
    logic dir_wr;
    logic dma;
    logic io_space;
    logic attr_mem;
    logic wide;
    logic no_inc;
  } xfer_mode_t;
endpackage

// File: rtl/cfx_ctrl_reg.sv
`timescale 1ns/1ps
module cfx_ctrl_reg
  import cfx_pkg::*;
#(
  parameter int COUNT_W  = 18,
  parameter int MAX_XFER = 32'h20000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  input  logic               busy_i,
  output logic               launch_o,
  output logic               abort_o,
  output logic [COUNT_W-1:0] launch_cnt_o,
  output xfer_mode_t         mode_o,
  output logic [COUNT_W-1:0] count_o
);
  localparam logic [COUNT_W-1:0] CAP = COUNT_W'(MAX_XFER);

  logic [COUNT_W-1:0] cnt_raw;
  logic               unused_bits;

  assign cnt_raw      = wdata_i[COUNT_W-1:0];
  assign launch_cnt_o = (cnt_raw > CAP) ? CAP : cnt_raw;
  assign launch_o     = we_i && wdata_i[START_BIT] && !busy_i;
  // start low while busy stops the run; fields stay put
  assign abort_o      = we_i && !wdata_i[START_BIT] && busy_i;
  assign unused_bits  = ^{wdata_i[29], wdata_i[23:COUNT_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      count_o <= '0;
    end else if (we_i && !busy_i) begin
      mode_o.dir_wr   <= wdata_i[DIR_BIT];
      mode_o.dma      <= wdata_i[DMA_BIT];
      mode_o.io_space <= wdata_i[IO_BIT];
      mode_o.attr_mem <= wdata_i[ATTR_BIT];
      mode_o.wide     <= wdata_i[WIDE_BIT];
      mode_o.no_inc   <= wdata_i[NOINC_BIT];
      count_o         <= launch_cnt_o;
    end
  end
endmodule

// File: rtl/cfx_byte_fifo.sv
`timescale 1ns/1ps
module cfx_byte_fifo #(
  parameter int DEPTH = 512,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [NW-1:0]      push_n_i,
  input  logic [8*LANES-1:0] push_data_i,
  input  logic [NW-1:0]      pop_n_i,
  output logic [8*LANES-1:0] peek_o,
  output logic [AW:0]        level_o
);
  logic [7:0] mem_q [DEPTH];
  logic [AW:0] wptr_q, rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_q + (AW+1)'(push_n_i);
      rptr_q <= rptr_q + (AW+1)'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (NW'(k) < push_n_i)
        mem_q[wptr_q[AW-1:0] + AW'(k)] <= push_data_i[8*k +: 8];
    end
  end

  assign level_o = wptr_q - rptr_q;

  // lanes past the fill level read as zero
  for (genvar g = 0; g < LANES; g++) begin : g_peek
    assign peek_o[8*g +: 8] = ((AW+1)'(g) < level_o) ?
                              mem_q[rptr_q[AW-1:0] + AW'(g)] : 8'h00;
  end
endmodule

// File: rtl/cfx_seq.sv
`timescale 1ns/1ps
module cfx_seq #(
  parameter int COUNT_W    = 18,
  parameter int FIFO_BYTES = 512,
  localparam int AW = $clog2(FIFO_BYTES),
  localparam int CW = $clog2(FIFO_BYTES + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [COUNT_W-1:0] launch_cnt_i,
  input  logic               stop_i,
  input  logic               dir_wr_i,
  input  logic               wide_i,
  input  logic [AW:0]        level_i,
  input  logic               card_ack_i,
  output logic               busy_o,
  output logic               card_req_o,
  output logic [1:0]         beat_n_o,
  output logic               buf_avail_o,
  output logic               xfer_done_o
);
  localparam logic [AW:0]   DEPTH_L = (AW+1)'(FIFO_BYTES);
  localparam logic [CW-1:0] CHUNK_L = CW'(FIFO_BYTES);

  logic               busy_q, buf_q, done_q;
  logic [COUNT_W-1:0] rem_q, rem_nx;
  logic [CW-1:0]      chunk_q, chunk_sum, chunk_nx;
  logic [1:0]         step;
  logic               room, beat, full;

  assign step = (wide_i && rem_q > COUNT_W'(1)) ? 2'd2 : 2'd1;
  assign room = dir_wr_i ? (level_i >= (AW+1)'(step))
                         : ((DEPTH_L - level_i) >= (AW+1)'(step));

  assign card_req_o = busy_q && room;
  assign beat       = card_req_o && card_ack_i && !stop_i;
  assign beat_n_o   = beat ? step : 2'd0;

  assign rem_nx    = rem_q - COUNT_W'(step);
  assign chunk_sum = chunk_q + CW'(step);
  assign full      = chunk_sum >= CHUNK_L;
  assign chunk_nx  = full ? chunk_sum - CHUNK_L : chunk_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      buf_q   <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      chunk_q <= '0;
    end else begin
      buf_q  <= 1'b0;
      done_q <= 1'b0;
      if (launch_i) begin
        rem_q   <= launch_cnt_i;
        chunk_q <= '0;
        if (launch_cnt_i == '0) done_q <= 1'b1;
        else                    busy_q <= 1'b1;
      end else if (busy_q && stop_i) begin
        busy_q <= 1'b0;
      end else if (beat) begin
        rem_q   <= rem_nx;
        chunk_q <= chunk_nx;
        // a write's last chunk frees space nobody will refill
        buf_q   <= full && (!dir_wr_i || rem_nx != '0);
        if (rem_nx == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign buf_avail_o = buf_q;
  assign xfer_done_o = done_q;
endmodule

// File: rtl/chunk_xfer_ctrl.sv
`timescale 1ns/1ps
module chunk_xfer_ctrl
  import cfx_pkg::*;
#(
  parameter int FIFO_BYTES = 512,
  parameter int COUNT_W    = 18,
  parameter int MAX_XFER   = 32'h20000,
  parameter int BUS_BYTES  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ctrl_we_i,
  input  logic [31:0]            ctrl_wdata_i,
  output logic [31:0]            ctrl_rdata_o,
  input  logic                   bus_push_i,
  input  logic [8*BUS_BYTES-1:0] bus_wdata_i,
  output logic                   bus_push_ready_o,
  input  logic                   bus_pop_i,
  output logic [8*BUS_BYTES-1:0] bus_rdata_o,
  output logic                   bus_pop_valid_o,
  output logic                   card_req_o,
  input  logic                   card_ack_i,
  output logic                   card_wide_o,
  input  logic [15:0]            card_rdata_i,
  output logic [15:0]            card_wdata_o,
  input  logic                   pio_err_i,
  output logic                   buf_avail_o,
  output logic                   xfer_done_o
);
  localparam int AW = $clog2(FIFO_BYTES);
  localparam int NW = $clog2(BUS_BYTES + 1);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(FIFO_BYTES);
  localparam logic [AW:0] WORD_L  = (AW+1)'(BUS_BYTES);

  xfer_mode_t         mode;
  logic [COUNT_W-1:0] count_q, launch_cnt;
  logic               launch, abort, busy;
  logic [1:0]         beat_n;
  logic [AW:0]        fifo_level, fifo_space;
  logic [NW-1:0]      push_n, pop_n, bus_pop_n;
  logic [8*BUS_BYTES-1:0] push_data, peek;
  logic               bus_push_fire, bus_pop_fire;

  cfx_ctrl_reg #(.COUNT_W(COUNT_W), .MAX_XFER(MAX_XFER)) u_reg (
    .clk_i, .rst_ni,
    .we_i        (ctrl_we_i),
    .wdata_i     (ctrl_wdata_i),
    .busy_i      (busy),
    .launch_o    (launch),
    .abort_o     (abort),
    .launch_cnt_o(launch_cnt),
    .mode_o      (mode),
    .count_o     (count_q)
  );

  cfx_seq #(.COUNT_W(COUNT_W), .FIFO_BYTES(FIFO_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .launch_i    (launch),
    .launch_cnt_i(launch_cnt),
    .stop_i      (abort || pio_err_i),
    .dir_wr_i    (mode.dir_wr),
    .wide_i      (mode.wide),
    .level_i     (fifo_level),
    .card_ack_i  (card_ack_i),
    .busy_o      (busy),
    .card_req_o  (card_req_o),
    .beat_n_o    (beat_n),
    .buf_avail_o (buf_avail_o),
    .xfer_done_o (xfer_done_o)
  );

  assign fifo_space       = DEPTH_L - fifo_level;
  assign bus_push_ready_o = busy && mode.dir_wr && (fifo_space >= WORD_L);
  assign bus_pop_valid_o  = !mode.dir_wr &&
                            ((fifo_level >= WORD_L) || (!busy && fifo_level != '0));
  assign bus_push_fire    = bus_push_i && bus_push_ready_o;
  assign bus_pop_fire     = bus_pop_i && bus_pop_valid_o;
  assign bus_pop_n        = (fifo_level >= WORD_L) ? NW'(BUS_BYTES) : NW'(fifo_level);

  always_comb begin
    if (mode.dir_wr) begin
      push_n    = bus_push_fire ? NW'(BUS_BYTES) : '0;
      push_data = bus_wdata_i;
      pop_n     = NW'(beat_n);
    end else begin
      push_n    = NW'(beat_n);
      push_data = {{(8*BUS_BYTES-16){1'b0}}, card_rdata_i};
      pop_n     = bus_pop_fire ? bus_pop_n : '0;
    end
  end

  cfx_byte_fifo #(.DEPTH(FIFO_BYTES), .LANES(BUS_BYTES)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i    (launch),
    .push_n_i   (push_n),
    .push_data_i(push_data),
    .pop_n_i    (pop_n),
    .peek_o     (peek),
    .level_o    (fifo_level)
  );

  assign bus_rdata_o  = mode.dir_wr ? '0 : peek;
  assign card_wdata_o = mode.dir_wr ? peek[15:0] : 16'h0000;
  assign card_wide_o  = mode.wide;

  assign ctrl_rdata_o = {busy, mode.dir_wr, 1'b0, mode.dma, mode.io_space,
                         mode.attr_mem, mode.wide, mode.no_inc,
                         {(24-COUNT_W){1'b0}}, count_q};
endmodule

// File: rtl/chunk_xfer_ctrl_chk.sv
`timescale 1ns/1ps
module chunk_xfer_ctrl_chk #(
  parameter int FIFO_BYTES = 512,
  parameter int COUNT_W    = 18,
  localparam int AW = $clog2(FIFO_BYTES)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [31:0] ctrl_wdata_i,
  input logic [31:0] ctrl_rdata_o,
  input logic        card_req_o,
  input logic        card_ack_i,
  input logic        pio_err_i,
  input logic        buf_avail_o,
  input logic        xfer_done_o,
  input logic [AW:0] fifo_level
);
  p_idle_no_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rdata_o[31] |-> !card_req_o);

  p_done_clears_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> !ctrl_rdata_o[31]);

  p_abort_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[31] && ctrl_we_i && !ctrl_wdata_i[31])
    |=> (!ctrl_rdata_o[31] && !xfer_done_o && !buf_avail_o));

  p_pio_stop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[31] && pio_err_i) |=> (!ctrl_rdata_o[31] && !xfer_done_o));

  p_busy_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rdata_o[31] && ctrl_we_i && ctrl_wdata_i[31]) |=> $stable(ctrl_rdata_o[30:0]));

  p_buf_after_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_avail_o |-> $past(card_req_o && card_ack_i));

  p_zero_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_rdata_o[31] && ctrl_we_i && ctrl_wdata_i[31] && ctrl_wdata_i[COUNT_W-1:0] == '0)
    |=> (xfer_done_o && !ctrl_rdata_o[31]));

  p_no_overflow_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= (AW+1)'(FIFO_BYTES));
endmodule

bind chunk_xfer_ctrl chunk_xfer_ctrl_chk #(.FIFO_BYTES(FIFO_BYTES), .COUNT_W(COUNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o),
  .card_req_o  (card_req_o),
  .card_ack_i  (card_ack_i),
  .pio_err_i   (pio_err_i),
  .buf_avail_o (buf_avail_o),
  .xfer_done_o (xfer_done_o),
  .fifo_level  (fifo_level)
);

// File: tb/chunk_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module chunk_xfer_ctrl_bench;
  localparam int FIFO = 16;
  localparam int MAXX = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        bus_push = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_push_ready;
  logic        bus_pop = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_pop_valid;
  logic        card_req;
  logic        card_ack = 1'b0;
  logic        card_wide;
  logic [15:0] card_rdata = '0;
  logic [15:0] card_wdata;
  logic        pio_err = 1'b0;
  logic        buf_avail;
  logic        xfer_done;

  int n_checks = 0;
  int n_errs = 0;

  always #2.5 clk = ~clk;

  chunk_xfer_ctrl #(.FIFO_BYTES(FIFO), .MAX_XFER(MAXX)) u_chunk_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .bus_push_i(bus_push), .bus_wdata_i(bus_wdata), .bus_push_ready_o(bus_push_ready),
    .bus_pop_i(bus_pop), .bus_rdata_o(bus_rdata), .bus_pop_valid_o(bus_pop_valid),
    .card_req_o(card_req), .card_ack_i(card_ack), .card_wide_o(card_wide),
    .card_rdata_i(card_rdata), .card_wdata_o(card_wdata),
    .pio_err_i(pio_err), .buf_avail_o(buf_avail), .xfer_done_o(xfer_done)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_write(logic [31:0] w);
    ctrl_we = 1'b1;
    ctrl_wdata = w;
    @(posedge clk);
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1", "readback", ctrl_rdata, 32'h0);
    chk("R1", "card_req", {31'b0, card_req}, 0);
    chk("R1", "push_ready", {31'b0, bus_push_ready}, 0);
    chk("R1", "pop_valid", {31'b0, bus_pop_valid}, 0);
    chk("R1", "buf_avail", {31'b0, buf_avail}, 0);
    chk("R1", "done", {31'b0, xfer_done}, 0);
  endtask

  task automatic test_zero();
    ctrl_write(32'h8000_0000);
    chk("R9", "done after zero start", {31'b0, xfer_done}, 1);
    chk("R9", "busy", {31'b0, ctrl_rdata[31]}, 0);
    chk("R9", "card_req", {31'b0, card_req}, 0);
    @(negedge clk);
    chk("R9", "done one cycle", {31'b0, xfer_done}, 0);
    chk("R9", "card_req later", {31'b0, card_req}, 0);
  endtask

  // mode: 0 normal, 1 restart while busy, 2 abort, 3 pio error
  task automatic run_xfer(int cnt, bit wr, bit wide, int mode, logic [3:0] extra);
    int eff, rem, chunk, lvl, m_in, m_out, n_buf, n_done, nb, n;
    bit m_busy, exp_buf, exp_done, ack, pop, push, inject, check_rst, finished;
    logic [31:0] word, rb;
    eff = (cnt > MAXX) ? MAXX : cnt;
    word = {1'b1, wr, 1'b0, extra[3], extra[2], extra[1], wide, extra[0], 6'b0, 18'(cnt)};
    ctrl_write(word);
    rb = {word[31:18], 18'(eff)};
    chk((cnt > MAXX) ? "R10" : "R2", "readback after start", ctrl_rdata, rb);
    m_busy = 1; rem = eff; chunk = 0; lvl = 0; m_in = 0; m_out = 0;
    exp_buf = 0; exp_done = 0; n_buf = 0; n_done = 0; check_rst = 0; finished = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      nb = (wide && rem >= 2) ? 2 : 1;
      if (check_rst) begin
        chk("R11", "readback after busy start", {1'b0, ctrl_rdata[30:0]}, {1'b0, rb[30:0]});
        check_rst = 0;
      end
      chk("R14", "card_req", {31'b0, card_req},
          {31'b0, m_busy && (wr ? lvl >= nb : (FIFO - lvl) >= nb)});
      chk(wr ? "R6" : "R5", "buf_avail", {31'b0, buf_avail}, {31'b0, exp_buf});
      chk("R7", "done", {31'b0, xfer_done}, {31'b0, exp_done});
      chk("R7", "start bit", {31'b0, ctrl_rdata[31]}, {31'b0, m_busy});
      if (buf_avail) n_buf++;
      if (xfer_done) n_done++;
      if (!m_busy && !exp_buf && !exp_done && (wr || lvl == 0)) begin
        finished = 1;
        break;
      end
      exp_buf = 0; exp_done = 0;
      ctrl_we = 0; pio_err = 0; bus_push = 0; bus_pop = 0;
      inject = (cyc == 6) && (mode != 0) && m_busy;
      ack = card_req && (cyc % 3 != 2) && !(inject && mode >= 2);
      card_ack = ack;
      card_rdata = {pat(m_in + 1), pat(m_in)};
      pop = 0; push = 0; n = 0;
      if (wr) begin
        if (ack) begin
          chk("R4", "card byte0", {24'b0, card_wdata[7:0]}, {24'b0, pat(m_out)});
          if (nb == 2) chk("R4", "card byte1", {24'b0, card_wdata[15:8]}, {24'b0, pat(m_out + 1)});
        end
        chk("R14", "push_ready", {31'b0, bus_push_ready}, {31'b0, m_busy && (FIFO - lvl) >= 4});
        push = m_busy && (FIFO - lvl) >= 4;
        bus_push = push;
        bus_wdata = {pat(m_in + 3), pat(m_in + 2), pat(m_in + 1), pat(m_in)};
      end else begin
        chk("R14", "pop_valid", {31'b0, bus_pop_valid}, {31'b0, lvl >= 4 || (!m_busy && lvl > 0)});
        pop = (lvl >= 4 || (!m_busy && lvl > 0)) && (cyc % 4 == 0 || !m_busy);
        bus_pop = pop;
        if (pop) begin
          n = (lvl >= 4) ? 4 : lvl;
          for (int k = 0; k < n; k++)
            chk("R3", "bus byte", {24'b0, bus_rdata[8*k +: 8]}, {24'b0, pat(m_out + k)});
        end
      end
      if (inject && mode == 1) begin
        ctrl_we = 1; ctrl_wdata = {1'b1, ~wr, 1'b0, 5'b10101, 6'b0, 18'd5};
      end
      if (inject && mode == 2) begin
        ctrl_we = 1; ctrl_wdata = 32'h0;
      end
      if (inject && mode == 3) pio_err = 1;
      @(posedge clk);
      if (inject && mode >= 2) m_busy = 0;
      else if (ack) begin
        rem -= nb;
        chunk += nb;
        if (wr) begin m_out += nb; lvl -= nb; end
        else begin m_in += nb; lvl += nb; end
        if (chunk >= FIFO) begin
          chunk -= FIFO;
          exp_buf = !wr || rem != 0;
        end
        if (rem == 0) begin m_busy = 0; exp_done = 1; end
      end
      if (pop) begin lvl -= n; m_out += n; end
      if (push) begin lvl += 4; m_in += 4; end
      if (inject && mode == 1) check_rst = 1;
      @(negedge clk);
    end
    ctrl_we = 0; pio_err = 0; bus_push = 0; bus_pop = 0; card_ack = 0;
    chk("R7", "transfer finished in time", {31'b0, finished}, 1);
    if (mode >= 2) begin
      chk(mode == 2 ? "R12" : "R13", "done count after stop", n_done, 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(mode == 2 ? "R12" : "R13", "req after stop", {31'b0, card_req}, 0);
        chk(mode == 2 ? "R12" : "R13", "no late done", {31'b0, xfer_done | buf_avail}, 0);
      end
    end else begin
      chk("R7", "done count", n_done, 1);
      chk(wr ? "R6" : "R5", "buf count", n_buf, wr ? (eff - 1) / FIFO : eff / FIFO);
      chk((wide && (eff % 2 == 1)) ? "R8" : (wr ? "R4" : "R3"), "bytes moved",
          wr ? m_out : m_in, eff);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_xfer(20, 0, 0, 0, 4'b0000);      // short final chunk
    run_xfer(32, 0, 1, 0, 4'b1001);      // last chunk full, read
    run_xfer(32, 1, 1, 0, 4'b0110);      // last chunk full, write
    run_xfer(7, 1, 0, 0, 4'b0000);
    run_xfer(19, 0, 1, 0, 4'b0000);      // odd count, 16-bit
    test_zero();
    run_xfer(18'h3FFFF, 0, 1, 0, 4'b0000); // clamp
    run_xfer(40, 0, 1, 1, 4'b0000);      // start while busy
    run_xfer(40, 1, 1, 2, 4'b0000);      // abort
    run_xfer(40, 0, 1, 3, 4'b0000);      // pio error
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule